// File: doc/BRIEF.md
# Frequency Window Lock Detector

This block decides whether a divided oscillator clock is running at the rate that a fixed reference clock says it should. All of its logic runs on the reference clock, which also clocks its timers. The divided oscillator clock arrives asynchronously. It passes through a two-flop synchronizer, and its rising edges are counted over a fixed window of reference cycles. At the end of each window the count is compared with an expected count for the selected line rate. The expected count is supplied on an input and can be changed along with the rate.

Lock uses hysteresis. A window counts as good when the count lies within 1% of the expected value. Two good windows in a row are needed to declare lock. Once lock is held, it is kept until a window lands more than 2% away from the expected value. That single window drops lock and raises a one-cycle loss pulse, which hands control back to frequency acquisition. A clear input is pulsed when the rate selection changes. It forces the unlocked state and restarts the window.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after `clr` is sampled high, `lock` and `lost` are both low. `clr` never produces a `lost` pulse.
- R2: Reset and `clr` restart the window. A window spans `WIN_CYCLES` consecutive reference cycles. Each rising edge of the synchronized `vco_div` is counted in exactly one window, and `lock` changes only at a window boundary.
- R3: A window is in the acquire band when |count - expected| <= floor(expected / ACQ_DIV). The default ACQ_DIV = 100 gives 1%, and the bound is inclusive.
- R4: From the unlocked state, `lock` rises after `ACQ_WINDOWS` (default 2) consecutive in-band windows. With a steady in-band input, it goes high at the clock edge 2*WIN_CYCLES edges after the last edge that sampled reset or clear.
- R5: Any window outside the acquire band while lock is being acquired sets the streak back to zero. Windows that alternate between in-band and out-of-band therefore never give lock.
- R6: While locked, a window with |count - expected| > floor(expected / LOSE_DIV) drops `lock`. The default LOSE_DIV = 50 gives 2%. Windows within that bound, including those between 1% and 2%, keep lock.
- R7: `lost` is a single-cycle pulse that is high exactly in the cycle in which `lock` falls because of a window outside the lose band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is on this clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear: force unlocked and restart the window |
| vco_div | input | 1 | Divided oscillator clock, asynchronous to `clk` |
| expected | input | CNT_W | Edge count expected per window for the selected rate |
| lock | output | 1 | High while frequency lock is held (registered) |
| lost | output | 1 | One-cycle pulse when lock is dropped by an out-of-band window |

## Verification
The bench builds the block with a 1000-cycle window and drives an expected count of 400 (and 300 for one case). At 400 the acquire and lose tolerances are 4 and 8 edges, so the edges of both bands can be hit exactly: counts of 404/405 test the acquire bound and 408/409 test the lose bound. The oscillator input is produced by a phase accumulator whose modulus equals the window length. This makes every window of steady stimulus hold exactly the chosen number of edges, whatever its alignment with the synchronizer. With clear aligning the windows, the bench can also switch the rate on window boundaries to exercise streak reset and the exact cycle at which lock rises.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HELD = 1'b1
  } lock_state_t;
endpackage

// File: rtl/flk_edge_sync.sv
module flk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= pipe[STAGES-1];
  end

  assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/flk_window.sv
module flk_window #(
  parameter int WIN_CYCLES = 1024,
  parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             rise,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  logic [WIN_W-1:0] phase;
  logic [CNT_W-1:0] edges;

  assign done  = (phase == WIN_W'(WIN_CYCLES - 1));
  assign count = edges + CNT_W'(rise);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
      edges <= '0;
    end else if (done) begin
      phase <= '0;
      edges <= '0;
    end else begin
      phase <= phase + 1'b1;
      edges <= count;
    end
  end
endmodule

// File: rtl/flk_band_judge.sv
module flk_band_judge #(
  parameter int CNT_W    = 11,
  parameter int ACQ_DIV  = 100,
  parameter int LOSE_DIV = 50
) (
  input  logic [CNT_W-1:0] expected,
  input  logic [CNT_W-1:0] measured,
  output logic             in_acq,
  output logic             out_lose
);
  logic [CNT_W-1:0] diff;
  logic [31:0]      acq_tol;
  logic [31:0]      lose_tol;

  always_comb begin
    if (measured >= expected) diff = measured - expected;
    else                      diff = expected - measured;
    acq_tol  = 32'(expected) / 32'(ACQ_DIV);
    lose_tol = 32'(expected) / 32'(LOSE_DIV);
    in_acq   = (32'(diff) <= acq_tol);
    out_lose = (32'(diff) >  lose_tol);
  end
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect
  import flk_pkg::*;
#(
  parameter int WIN_CYCLES  = 1024,
  parameter int CNT_W       = $clog2(WIN_CYCLES + 1),
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_DIV     = 100,
  parameter int LOSE_DIV    = 50,
  parameter int ACQ_WINDOWS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vco_div,
  input  logic [CNT_W-1:0] expected,
  output logic             lock,
  output logic             lost
);
  localparam int STREAK_W = $clog2(ACQ_WINDOWS + 1);

  logic             rise;
  logic             done;
  logic [CNT_W-1:0] count;
  logic             in_acq;
  logic             out_lose;
  lock_state_t      state;
  logic [STREAK_W-1:0] streak;

  flk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(vco_div), .rise(rise)
  );

  flk_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .restart(clr), .rise(rise),
    .done(done), .count(count)
  );

  flk_band_judge #(.CNT_W(CNT_W), .ACQ_DIV(ACQ_DIV), .LOSE_DIV(LOSE_DIV)) u_judge (
    .expected(expected), .measured(count),
    .in_acq(in_acq), .out_lose(out_lose)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state  <= ST_HUNT;
      streak <= '0;
      lost   <= 1'b0;
    end else begin
      lost <= 1'b0;
      if (done) begin
        case (state)
          ST_HUNT: begin
            if (!in_acq) begin
              streak <= '0;
            end else if (streak == STREAK_W'(ACQ_WINDOWS - 1)) begin
              streak <= '0;
              state  <= ST_HELD;
            end else begin
              streak <= streak + 1'b1;
            end
          end
          ST_HELD: begin
            if (out_lose) begin
              state <= ST_HUNT;
              lost  <= 1'b1;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign lock = (state == ST_HELD);
endmodule

// File: rtl/flk_checker.sv
module flk_checker #(
  parameter int WIN_CYCLES = 1024
) (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic lock,
  input logic lost
);
  localparam int PH_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || clr)                         ph <= '0;
    else if (ph == PH_W'(WIN_CYCLES - 1))   ph <= '0;
    else                                    ph <= ph + 1'b1;
  end

  // R1
  clr_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!lock && !lost));

  // R2
  lock_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (ph == '0));

  // R6
  loss_edge_chk: assert property (@(posedge clk) disable iff (rst)
    lost |-> (ph == '0));

  // R7
  lost_fall_chk: assert property (@(posedge clk) disable iff (rst)
    lost |-> ($past(lock) && !lock));

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> (lost || $past(clr)));
endmodule

bind freq_lock_detect flk_checker #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .lock(lock), .lost(lost)
);

// File: tb/sim_freq_lock_detect.sv
module sim_freq_lock_detect;
  localparam int WIN = 1000;
  localparam int E0  = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       vco = 1'b0;
  logic [9:0] expected = 10'(E0);
  logic       lock;
  logic       lost;

  int checks = 0;
  int errors = 0;
  int k_rate = E0;
  int acc    = 0;
  int lost_total = 0;
  int lock_total = 0;
  int wd = 0;

  freq_lock_detect #(.WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .vco_div(vco),
    .expected(expected), .lock(lock), .lost(lost)
  );

  always #2 clk = ~clk;

  // Phase accumulator, modulus = window: every WIN-cycle span holds k_rate edges
  always @(negedge clk) begin
    if (acc + k_rate >= WIN) begin
      acc <= acc + k_rate - WIN;
      vco <= 1'b1;
    end else begin
      acc <= acc + k_rate;
      vco <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (lost) lost_total <= lost_total + 1;
    if (lock) lock_total <= lock_total + 1;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", wd);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic settle();
    cyc(3 * WIN + 10);
  endtask

  // 0: acquire band, 1: between bands, 2: beyond lose band
  function automatic int band_of(input int k, input int e);
    int d;
    d = (k >= e) ? k - e : e - k;
    if (d <= e / 100) return 0;
    if (d <= e / 50)  return 1;
    return 2;
  endfunction

  task automatic step_rate(input int k, input int exp_lock, input int exp_lost,
                           input string req);
    int base;
    base = lost_total;
    k_rate = k;
    settle();
    chk({req, " lock"}, int'(lock), exp_lock);
    chk({req, " lost pulses"}, lost_total - base, exp_lost);
  endtask

  initial begin
    int model_lock;
    void'($urandom(32'd4242));

    // R1: reset state
    cyc(5);
    chk("R1 reset lock", int'(lock), 0);
    chk("R1 reset lost", int'(lost), 0);

    // R4 / R2: lock rises exactly 2*WIN edges after the last reset edge
    @(negedge clk) rst = 1'b0;
    cyc(2 * WIN - 1);
    chk("R4 lock before second window end", int'(lock), 0);
    cyc(1);
    chk("R4 lock at second window end", int'(lock), 1);

    // Different rate: expected 300, then aligned clear
    expected = 10'd300;
    k_rate   = 300;
    settle();
    do_clear();
    chk("R1 clear drops lock", int'(lock), 0);
    chk("R1 clear gives no lost", int'(lost), 0);
    cyc(2 * WIN - 1);
    chk("R2 window restarted by clear", int'(lock), 0);
    cyc(1);
    chk("R3 lock at expected 300", int'(lock), 1);

    expected = 10'(E0);
    k_rate   = E0;
    settle();
    chk("R3 relock at expected 400", int'(lock), 1);

    // Band boundaries (tolerances 4 and 8 at 400)
    step_rate(408, 1, 0, "R6 at 2% edge keeps lock");
    step_rate(409, 0, 1, "R6 beyond 2% drops lock R7");
    step_rate(405, 0, 0, "R3 just outside 1% no acquire");
    step_rate(404, 1, 0, "R3 at 1% edge acquires");
    step_rate(396, 1, 0, "R3 low side in band");
    step_rate(391, 0, 1, "R6 low side beyond 2% R7");

    // R5: alternate in-band and out-of-band per window after an aligned clear
    k_rate = E0;
    settle();
    do_clear();
    begin
      int base_lock;
      base_lock = lock_total;
      cyc(WIN - 1);
      for (int w = 1; w <= 6; w++) begin
        k_rate = (w % 2 == 1) ? 440 : E0;
        cyc(WIN);
      end
      chk("R5 alternating windows never lock", lock_total - base_lock, 0);
    end
    settle();
    chk("R5 steady in-band after alternation locks", int'(lock), 1);

    // Random rate changes against the band model
    model_lock = 1;
    for (int s = 0; s < 16; s++) begin
      int cat;
      int d;
      int k;
      int exp_lost;
      cat = $urandom_range(0, 2);
      if (cat == 0)      d = $urandom_range(0, 3);
      else if (cat == 1) d = $urandom_range(5, 7);
      else               d = $urandom_range(12, 40);
      k = ($urandom_range(0, 1) == 1) ? E0 + d : E0 - d;
      exp_lost = 0;
      case (band_of(k, E0))
        0: model_lock = 1;
        2: begin
          if (model_lock == 1) exp_lost = 1;
          model_lock = 0;
        end
        default: ;
      endcase
      step_rate(k, model_lock, exp_lost, "R6 random rate");
    end

    summary();
  end
endmodule